// File: doc/BRIEF.md
# Macro-Pixel Freeze and Snapshot Queue

This block sits between a pixel matrix and a time-ordered readout sweeper. The matrix is divided into macro pixels, and each one raises a level "fired" flag when any of its pixels has been hit. On every bunch-crossing strobe, the block takes the fired macro pixels that are not already frozen and freezes them. It then pushes one snapshot into a shallow queue. Each snapshot holds the pattern of newly frozen macro pixels and the value of a free-running bunch-crossing timestamp.

The sweeper drains the queue through a valid/ready stream. The queue is first-in first-out, so snapshots leave in timestamp order. After the sweeper has read out the pixels of a snapshot, it returns a clear mask, and the macro pixels in that mask unfreeze. When a bunch crossing has fresh fired macro pixels but the queue is full, no hit is thrown away. The freeze is postponed to a later strobe, and a saturating lost-bunch-crossing counter records the event. This tells the user that the timing resolution for that interval has degraded.

Back-pressure rules on the snapshot stream:
- `snap_valid` stays high, and `snap_ts` and `snap_pattern` stay stable, until `snap_ready` is sampled high at a rising clock edge.
- A transfer happens on any edge where both `snap_valid` and `snap_ready` are high.
- The queue is judged full before that edge's transfer is applied, so a pop cannot make room for a push on the same edge.

Top module: `mp_freeze_queue`

## Requirements
- R1: At a clock edge with `bc_strobe` high, the candidate pattern is `mp_fired & ~frozen`. If that pattern is nonzero and the queue is not full, one snapshot {timestamp, candidate pattern} is pushed and those macro pixels become frozen. An empty queue shows the snapshot on `snap_valid`/`snap_ts`/`snap_pattern` right after that edge.
- R2: The queue holds up to DEPTH (default 4) snapshots and delivers them in push order, which is timestamp order. While `snap_valid` is high and `snap_ready` is low, the head snapshot stays stable.
- R3: A frozen macro pixel is left out of every candidate pattern. A hit on it is not captured by any strobe while it stays frozen.
- R4: A `sweep_clr_valid` pulse unfreezes every macro pixel whose `sweep_clr_mask` bit is 1, from the next edge on. A later strobe captures such a pixel again if it is still fired. The candidate at the same edge as the clear still sees the old frozen state.
- R5: A strobe with a nonzero candidate while the queue is full pushes nothing and freezes nothing. It raises `lost_bc_count` by one. The still-fired macro pixels are captured at the first later strobe that finds room.
- R6: `lost_bc_count` (LOST_W bits, default 4) saturates at its all-ones value. `lost_bc_clear` sets it to 0 at the next edge and takes priority over an increment in the same cycle.
- R7: A strobe whose candidate pattern is zero pushes nothing and leaves `lost_bc_count` unchanged.
- R8: The timestamp starts at 0 after reset. It increments by one on every strobe, whether or not a snapshot is pushed, and wraps modulo 2^TS_W. A snapshot carries the value from before that strobe's increment.
- R9: While `rst_n` is low (asynchronous, active low), the queue is empty, no macro pixel is frozen, the timestamp is 0 and `lost_bc_count` is 0.
- R10: When a full queue pops at the same edge as a strobe with a nonzero candidate, the push is refused and counted as lost, as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bc_strobe | input | 1 | One-cycle bunch-crossing strobe |
| mp_fired | input | NUM_MP | Level fired flag per macro pixel |
| sweep_clr_valid | input | 1 | Sweeper readout-done pulse |
| sweep_clr_mask | input | NUM_MP | Macro pixels to unfreeze |
| snap_valid | output | 1 | Head snapshot available |
| snap_ready | input | 1 | Sweeper accepts head snapshot |
| snap_ts | output | TS_W | Timestamp of head snapshot |
| snap_pattern | output | NUM_MP | Frozen pattern of head snapshot |
| lost_bc_count | output | LOST_W | Saturating lost-bunch-crossing count |
| lost_bc_clear | input | 1 | Synchronous clear of the lost count |

## Verification
The bench fills the queue with overlapping fired patterns, so that a design which forgot to mask frozen macro pixels would queue the same pixel twice. It strobes against a full queue, with and without a pop on the same edge. A design that let the pop free the slot, or that dropped the hits instead of postponing the freeze, would show a wrong head or a missing delayed snapshot. It drives the lost counter well past its ceiling and clears it during a lossy strobe, which exposes wrap-around or a wrong priority. It also runs the timestamp through its wrap point and checks the value on each side. An off-by-one stamping or a counter that advanced only on pushes would then show up.

// File: rtl/mpq_pkg.sv
package mpq_pkg;
  localparam int unsigned MPQ_NUM_MP = 8;
  localparam int unsigned MPQ_TS_W   = 8;
  localparam int unsigned MPQ_DEPTH  = 4;
  localparam int unsigned MPQ_LOST_W = 4;
endpackage

// File: rtl/mpq_freeze.sv
module mpq_freeze #(
  parameter int unsigned NUM_MP = 8,
  parameter int unsigned TS_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bc_strobe,
  input  logic [NUM_MP-1:0] fired_i,
  input  logic              clr_valid_i,
  input  logic [NUM_MP-1:0] clr_mask_i,
  input  logic              room_i,
  output logic              push_o,
  output logic              lost_evt_o,
  output logic [NUM_MP-1:0] push_pat_o,
  output logic [TS_W-1:0]   push_ts_o,
  output logic [NUM_MP-1:0] frozen_o
);
  logic [NUM_MP-1:0] frozen_q, frozen_d, cand;
  logic [TS_W-1:0]   ts_q;
  logic              has_cand;

  assign cand       = fired_i & ~frozen_q;
  assign has_cand   = |cand;
  assign push_o     = bc_strobe & has_cand & room_i;
  assign lost_evt_o = bc_strobe & has_cand & ~room_i;
  assign push_pat_o = cand;
  assign push_ts_o  = ts_q;
  assign frozen_o   = frozen_q;

  for (genvar i = 0; i < NUM_MP; i++) begin : g_mp
    always_comb begin
      if (push_o && cand[i])                  frozen_d[i] = 1'b1;
      else if (clr_valid_i && clr_mask_i[i])  frozen_d[i] = 1'b0;
      else                                    frozen_d[i] = frozen_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen_q <= '0;
      ts_q     <= '0;
    end else begin
      frozen_q <= frozen_d;
      if (bc_strobe) ts_q <= ts_q + TS_W'(1);
    end
  end

  assert_ts_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bc_strobe |=> ts_q == $past(ts_q) + TS_W'(1));

  assert_capture_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> (frozen_q & $past(push_pat_o)) == $past(push_pat_o));

  assert_frozen_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_valid_i |=> (frozen_q & $past(frozen_q)) == $past(frozen_q));
endmodule

// File: rtl/mpq_fifo.sv
module mpq_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  output logic         full_o,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o      = (cnt_q == CW'(DEPTH));
  assign out_valid_o = (cnt_q != '0);
  assign out_data_o  = mem_q[rd_q];
  assign do_push     = push_i & ~full_o;
  assign do_pop      = out_valid_o & out_ready_i;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= step_ptr(wr_q);
      if (do_pop)  rd_q <= step_ptr(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_data_i;
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  assert_head_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
endmodule

// File: rtl/mpq_lost_ctr.sv
module mpq_lost_ctr #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         clear_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;
  logic         at_max;

  assign at_max  = &cnt_q;
  assign count_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (inc_i && !at_max)  cnt_q <= cnt_q + W'(1);
  end

  assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && !clear_i) |=> at_max);

  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> cnt_q == '0);
endmodule

// File: rtl/mp_freeze_queue.sv
module mp_freeze_queue
  import mpq_pkg::*;
#(
  parameter int unsigned NUM_MP = MPQ_NUM_MP,
  parameter int unsigned TS_W   = MPQ_TS_W,
  parameter int unsigned DEPTH  = MPQ_DEPTH,
  parameter int unsigned LOST_W = MPQ_LOST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bc_strobe,
  input  logic [NUM_MP-1:0] mp_fired,
  input  logic              sweep_clr_valid,
  input  logic [NUM_MP-1:0] sweep_clr_mask,
  output logic              snap_valid,
  input  logic              snap_ready,
  output logic [TS_W-1:0]   snap_ts,
  output logic [NUM_MP-1:0] snap_pattern,
  output logic [LOST_W-1:0] lost_bc_count,
  input  logic              lost_bc_clear
);
  localparam int unsigned ENT_W = TS_W + NUM_MP;

  logic              q_full, push, lost_evt;
  logic [NUM_MP-1:0] push_pat, frozen;
  logic [TS_W-1:0]   push_ts;
  logic [ENT_W-1:0]  head;

  mpq_freeze #(.NUM_MP(NUM_MP), .TS_W(TS_W)) freeze_i (
    .clk(clk), .rst_n(rst_n), .bc_strobe(bc_strobe), .fired_i(mp_fired),
    .clr_valid_i(sweep_clr_valid), .clr_mask_i(sweep_clr_mask),
    .room_i(~q_full), .push_o(push), .lost_evt_o(lost_evt),
    .push_pat_o(push_pat), .push_ts_o(push_ts), .frozen_o(frozen));

  mpq_fifo #(.W(ENT_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push_i(push), .push_data_i({push_ts, push_pat}),
    .full_o(q_full), .out_valid_o(snap_valid), .out_ready_i(snap_ready),
    .out_data_o(head));

  mpq_lost_ctr #(.W(LOST_W)) lost_i (
    .clk(clk), .rst_n(rst_n), .inc_i(lost_evt), .clear_i(lost_bc_clear),
    .count_o(lost_bc_count));

  assign snap_ts      = head[ENT_W-1:NUM_MP];
  assign snap_pattern = head[NUM_MP-1:0];

  assert_full_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !push);

  assert_full_counts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_strobe && q_full && !lost_bc_clear && !(&lost_bc_count) &&
     ((mp_fired & ~frozen) != '0))
    |=> lost_bc_count == $past(lost_bc_count) + LOST_W'(1));

  assert_empty_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_strobe && ((mp_fired & ~frozen) == '0) && !lost_bc_clear)
    |=> $stable(lost_bc_count));
endmodule

// File: tb/mp_freeze_queue_tb_top.sv
module mp_freeze_queue_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bc_strobe = 1'b0;
  logic [7:0] mp_fired = '0;
  logic       sweep_clr_valid = 1'b0;
  logic [7:0] sweep_clr_mask = '0;
  logic       snap_valid;
  logic       snap_ready = 1'b0;
  logic [7:0] snap_ts;
  logic [7:0] snap_pattern;
  logic [3:0] lost_bc_count;
  logic       lost_bc_clear = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mp_freeze_queue dut_i (
    .clk(clk), .rst_n(rst_n), .bc_strobe(bc_strobe), .mp_fired(mp_fired),
    .sweep_clr_valid(sweep_clr_valid), .sweep_clr_mask(sweep_clr_mask),
    .snap_valid(snap_valid), .snap_ready(snap_ready), .snap_ts(snap_ts),
    .snap_pattern(snap_pattern), .lost_bc_count(lost_bc_count),
    .lost_bc_clear(lost_bc_clear));

  typedef struct packed {
    logic [7:0] fired;
    logic       bc;
    logic       clrv;
    logic [7:0] clrm;
    logic       rdy;
    logic       lclr;
    logic       ev;
    logic [7:0] ets;
    logic [7:0] epat;
    logic [3:0] elost;
  } row_t;

  localparam int NROWS = 16;
  localparam row_t ROWS [NROWS] = '{
    '{8'h00,1'b1,1'b0,8'h00,1'b0,1'b0, 1'b0,8'h00,8'h00,4'd0}, // R7 empty strobe
    '{8'h05,1'b1,1'b0,8'h00,1'b0,1'b0, 1'b1,8'h01,8'h05,4'd0}, // R1 R8 first push
    '{8'h07,1'b1,1'b0,8'h00,1'b0,1'b0, 1'b1,8'h01,8'h05,4'd0}, // R3 only bit1 new
    '{8'h07,1'b1,1'b0,8'h00,1'b0,1'b0, 1'b1,8'h01,8'h05,4'd0}, // R3 R7 nothing new
    '{8'h18,1'b1,1'b0,8'h00,1'b0,1'b0, 1'b1,8'h01,8'h05,4'd0}, // R2 hold head
    '{8'h38,1'b1,1'b0,8'h00,1'b0,1'b0, 1'b1,8'h01,8'h05,4'd0}, // R2 queue full
    '{8'hF8,1'b1,1'b0,8'h00,1'b0,1'b0, 1'b1,8'h01,8'h05,4'd1}, // R5 lost
    '{8'hF8,1'b1,1'b0,8'h00,1'b1,1'b0, 1'b1,8'h02,8'h02,4'd2}, // R10 pop+strobe full
    '{8'hF8,1'b1,1'b0,8'h00,1'b0,1'b0, 1'b1,8'h02,8'h02,4'd2}, // R5 delayed capture
    '{8'h00,1'b0,1'b0,8'h00,1'b1,1'b0, 1'b1,8'h04,8'h18,4'd2}, // R2 order
    '{8'h00,1'b0,1'b0,8'h00,1'b1,1'b0, 1'b1,8'h05,8'h20,4'd2}, // R2 order
    '{8'h00,1'b0,1'b0,8'h00,1'b1,1'b0, 1'b1,8'h08,8'hC0,4'd2}, // R5 R2 late ts
    '{8'h00,1'b0,1'b0,8'h00,1'b1,1'b0, 1'b0,8'h00,8'h00,4'd2}, // R2 drained
    '{8'hFF,1'b1,1'b1,8'h0F,1'b0,1'b0, 1'b0,8'h00,8'h00,4'd2}, // R4 clear sees old state
    '{8'hFF,1'b1,1'b0,8'h00,1'b0,1'b0, 1'b1,8'h0A,8'h0F,4'd2}, // R4 recapture
    '{8'h00,1'b0,1'b0,8'h00,1'b0,1'b1, 1'b1,8'h0A,8'h0F,4'd0}  // R6 clear
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] f, input logic bc, input logic cv,
                       input logic [7:0] cm, input logic rdy, input logic lc);
    @(negedge clk);
    mp_fired = f; bc_strobe = bc; sweep_clr_valid = cv;
    sweep_clr_mask = cm; snap_ready = rdy; lost_bc_clear = lc;
    @(posedge clk);
    #1;
    @(negedge clk);
    bc_strobe = 1'b0; sweep_clr_valid = 1'b0; snap_ready = 1'b0;
    lost_bc_clear = 1'b0;
  endtask

  task automatic chk_head(input string tag, input logic [7:0] ts, input logic [7:0] pat);
    chk({tag, " valid"}, int'(snap_valid), 1);
    chk({tag, " ts"}, int'(snap_ts), int'(ts));
    chk({tag, " pattern"}, int'(snap_pattern), int'(pat));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset valid", int'(snap_valid), 0);
    chk("R9 reset lost", int'(lost_bc_count), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int r = 0; r < NROWS; r++) begin
      drive(ROWS[r].fired, ROWS[r].bc, ROWS[r].clrv, ROWS[r].clrm,
            ROWS[r].rdy, ROWS[r].lclr);
      chk($sformatf("row %0d valid", r), int'(snap_valid), int'(ROWS[r].ev));
      if (ROWS[r].ev) begin
        chk($sformatf("row %0d ts", r), int'(snap_ts), int'(ROWS[r].ets));
        chk($sformatf("row %0d pattern", r), int'(snap_pattern), int'(ROWS[r].epat));
      end
      chk($sformatf("row %0d lost", r), int'(lost_bc_count), int'(ROWS[r].elost));
    end

    // R6 saturation: unfreeze all, fill queue, then strobe many times
    drive(8'h00, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0);
    drive(8'h01, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    drive(8'h03, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    drive(8'h07, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    for (int k = 0; k < 20; k++) drive(8'hFF, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R6 saturated", int'(lost_bc_count), 15);
    chk_head("R5 no push while full", 8'h0A, 8'h0F);
    drive(8'hFF, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1);
    chk("R6 clear beats increment", int'(lost_bc_count), 0);
    drive(8'hFF, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R5 lost after clear", int'(lost_bc_count), 1);

    // R2 ordering of the filled queue
    drive(8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    chk_head("R2 pop1", 8'h0B, 8'h01);
    drive(8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    chk_head("R2 pop2", 8'h0C, 8'h02);
    drive(8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    chk_head("R2 pop3", 8'h0D, 8'h04);

    // R9 mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    chk("R9 mid reset valid", int'(snap_valid), 0);
    chk("R9 mid reset lost", int'(lost_bc_count), 0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(8'h01, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    chk_head("R9 ts restarts", 8'h00, 8'h01);

    // R8 wrap of the timestamp
    drive(8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    chk("R8 drained", int'(snap_valid), 0);
    for (int k = 0; k < 254; k++) drive(8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    drive(8'h02, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    chk_head("R8 last before wrap", 8'hFF, 8'h02);
    drive(8'h06, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
    chk_head("R8 R1 wrapped ts", 8'h00, 8'h04);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule